// File: doc/BRIEF.md
# Flash configuration loader

This block loads a configuration image out of a parallel flash device into an FPGA that is configured passively. Flash is divided into equal pages, and each page holds one image. After reset the loader latches a page number. In normal operation that number comes from a set of local select pins. When remote update is enabled, it comes from a second set of pins that the target FPGA drives. The loader then pulls the FPGA's configuration-request line low for a fixed number of cycles. It waits for the FPGA to report that it is ready, and after that it streams the page out word by word.

Each flash word is 8 or 16 bits wide. A word is read with an active-low output enable that is held for a fixed latency, and then the word is captured. In serial mode the loader shifts the word out one bit per generated configuration clock. In parallel mode it presents one byte per configuration clock. The configuration clock stops when the FPGA signals that configuration is complete. If the last word of the page has been sent and the FPGA has still not signalled completion, the loader raises an error flag and stops.

Top module: `cfg_loader`

## Requirements
- R1: While `rst` is high: `cfg_nconfig` is 1, `cfg_dclk` is 0, `flash_oe_n` is 1, `busy` is 0, `err` is 0 and `flash_addr` is 0.
- R2: After reset is released, `cfg_nconfig` is driven low for exactly NCFG_LOW consecutive clock cycles, once, and then stays high.
- R3: While `cfg_nstatus` stays low after the request pulse, no flash read is started (`flash_oe_n` stays 1) and `cfg_dclk` does not pulse.
- R4: The page is taken from `sel_remote` when `remote_en` is 1 and from `sel_local` when it is 0. The other select set is ignored. The first flash address read is page × PAGE_WORDS.
- R5: Each flash read holds `flash_oe_n` low for exactly RD_LAT cycles. Successive reads use consecutive addresses, starting at the page base.
- R6: In serial mode (`par_mode`=0) with `wide16`=0, each word gives 8 bits on `cfg_d0`, bit 0 first, one bit per rising edge of `cfg_dclk`. Bits 15:8 of `flash_dq` are not used.
- R7: In serial mode with `wide16`=1, each word gives 16 bits: bit 0 through bit 15, so the low byte goes out before the high byte.
- R8: In parallel mode (`par_mode`=1), `cfg_dpar` carries one byte per rising edge of `cfg_dclk`. With `wide16`=0 this is bits 7:0 of each word. With `wide16`=1 it is bits 7:0 and then bits 15:8.
- R9: Once `cfg_done` is high, `cfg_dclk` stops within one cycle, even in the middle of a word. No further read starts, `busy` falls and `err` stays 0.
- R10: When all PAGE_WORDS words of the page have been sent and `cfg_done` is still low, `err` rises, `busy` falls and `cfg_dclk` stays low from then on.
- R11: `cfg_dclk` is high for exactly one clock cycle per pulse. `cfg_d0` and `cfg_dpar` do not change while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 1 | 0 = serial output, 1 = byte-wide output |
| wide16 | input | 1 | 0 = 8-bit flash words, 1 = 16-bit flash words |
| remote_en | input | 1 | Take the page from `sel_remote` instead of `sel_local` |
| sel_local | input | PB | Page number from local select pins |
| sel_remote | input | PB | Page number driven by the target FPGA |
| flash_dq | input | DW | Flash read data |
| flash_addr | output | AW | Flash word address |
| flash_oe_n | output | 1 | Flash output enable, active low |
| cfg_nconfig | output | 1 | Configuration request to the FPGA, active low |
| cfg_nstatus | input | 1 | FPGA ready status, high when ready |
| cfg_done | input | 1 | FPGA configuration complete |
| cfg_dclk | output | 1 | Generated configuration clock |
| cfg_d0 | output | 1 | Serial configuration data |
| cfg_dpar | output | 8 | Byte-wide configuration data |
| busy | output | 1 | Loader is running |
| err | output | 1 | Page exhausted before completion |

## Verification
A wrong page latch or a miscomputed base address appears at `flash_addr` on the first read, about NCFG_LOW plus a few cycles after reset. A fault in the address counter or the word counter shows up on the next read, or as a read count that differs from the one expected when the page runs out. A serializer that shifts by the wrong step, or loses its position in a word, corrupts the stream captured at the first `cfg_dclk` pulse that lands on the faulty bit or byte. A wrong state in the control sequencer shows up as missing, extra or stretched clock pulses, as a read that starts too early, or as a wrong `err` or `busy` level once the run is over.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  // sequencer states of the loader
  typedef enum logic [2:0] {
    S_IDLE,
    S_PULSE,
    S_WAIT,
    S_READ,
    S_SHIFT,
    S_DONE,
    S_ERR
  } ld_state_e;
endpackage

// File: rtl/cfg_page_sel.sv
module cfg_page_sel #(
  parameter int PB         = 2,
  parameter int AW         = 12,
  parameter int PAGE_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic          remote_en,
  input  logic [PB-1:0] sel_local,
  input  logic [PB-1:0] sel_remote,
  output logic [AW-1:0] base_addr
);
  logic [PB-1:0] pick;

  always_comb pick = remote_en ? sel_remote : sel_local;

  // page base is latched once, at the start of a run
  always_ff @(posedge clk) begin
    if (rst) base_addr <= '0;
    else if (capture) base_addr <= AW'(pick) * AW'(PAGE_WORDS);
  end
endmodule

// File: rtl/cfg_flash_rd.sv
module cfg_flash_rd #(
  parameter int AW         = 12,
  parameter int DW         = 16,
  parameter int RD_LAT     = 3,
  parameter int PAGE_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_addr,
  input  logic [AW-1:0] base_addr,
  input  logic          start,
  input  logic          next,
  input  logic [DW-1:0] flash_dq,
  output logic [AW-1:0] flash_addr,
  output logic          flash_oe_n,
  output logic          data_valid,
  output logic [DW-1:0] data_q,
  output logic          last_word
);
  localparam int LW = $clog2(RD_LAT + 1);
  localparam int WW = $clog2(PAGE_WORDS + 1);

  logic [AW-1:0] addr_q;
  logic [LW-1:0] lat_q;
  logic [WW-1:0] wcnt_q;
  logic          oe_n_q;
  logic          valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wcnt_q  <= '0;
      oe_n_q  <= 1'b1;
      lat_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (load_addr) begin
        addr_q <= base_addr;
        wcnt_q <= '0;
      end else if (next) begin
        addr_q <= addr_q + 1'b1;
        wcnt_q <= wcnt_q + 1'b1;
      end
      if (start) begin
        oe_n_q <= 1'b0;
        lat_q  <= '0;
      end else if (!oe_n_q) begin
        if (lat_q == LW'(RD_LAT - 1)) begin
          data_q  <= flash_dq;
          oe_n_q  <= 1'b1;
          valid_q <= 1'b1;
        end else begin
          lat_q <= lat_q + 1'b1;
        end
      end
    end
  end

  assign flash_addr = addr_q;
  assign flash_oe_n = oe_n_q;
  assign data_valid = valid_q;
  assign last_word  = (wcnt_q == WW'(PAGE_WORDS - 1));

  // R5: outside a page load the address only ever steps by one
  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_addr) && flash_addr != $past(flash_addr))
      |-> flash_addr == $past(flash_addr) + 1'b1);

  // R5: a read is never restarted while one is in progress
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (!flash_oe_n && !data_valid) |-> !start);
endmodule

// File: rtl/cfg_out_shift.sv
module cfg_out_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          wide16,
  input  logic          par_mode,
  input  logic [DW-1:0] word_in,
  output logic          cfg_d0,
  output logic [7:0]    cfg_dpar,
  output logic          last_unit
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sh_q, sh_nxt;
  logic [CW-1:0] left_q, units_m1;

  always_comb begin
    if (par_mode) units_m1 = wide16 ? CW'(1) : CW'(0);
    else          units_m1 = wide16 ? CW'(15) : CW'(7);
    sh_nxt = par_mode ? (sh_q >> 8) : (sh_q >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      left_q   <= '0;
      cfg_d0   <= 1'b0;
      cfg_dpar <= '0;
    end else if (load) begin
      sh_q     <= word_in;
      left_q   <= units_m1;
      cfg_d0   <= word_in[0];
      cfg_dpar <= word_in[7:0];
    end else if (step) begin
      sh_q     <= sh_nxt;
      left_q   <= left_q - 1'b1;
      cfg_d0   <= sh_nxt[0];
      cfg_dpar <= sh_nxt[7:0];
    end
  end

  assign last_unit = (left_q == '0);

  // R6/R7/R8: a step never runs past the units of the current word
  a_r6_step_in_word: assert property (@(posedge clk) disable iff (rst)
    step |-> left_q != '0);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int AW         = 12,
  parameter int PB         = 2,
  parameter int DW         = 16,
  parameter int PAGE_WORDS = 16,
  parameter int RD_LAT     = 3,
  parameter int NCFG_LOW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          par_mode,
  input  logic          wide16,
  input  logic          remote_en,
  input  logic [PB-1:0] sel_local,
  input  logic [PB-1:0] sel_remote,
  input  logic [DW-1:0] flash_dq,
  output logic [AW-1:0] flash_addr,
  output logic          flash_oe_n,
  output logic          cfg_nconfig,
  input  logic          cfg_nstatus,
  input  logic          cfg_done,
  output logic          cfg_dclk,
  output logic          cfg_d0,
  output logic [7:0]    cfg_dpar,
  output logic          busy,
  output logic          err
);
  localparam int PCW = $clog2(NCFG_LOW + 1);

  ld_state_e      state_q, state_d;
  logic [PCW-1:0] cnt_q, cnt_d;
  logic           nconfig_q, nconfig_d, dclk_q, dclk_d, err_q, err_d, busy_q;
  logic           capture, load_addr, rd_start, rd_next, sh_load, sh_step;
  logic           rd_valid, last_word, last_unit;
  logic [AW-1:0]  base_addr;
  logic [DW-1:0]  rd_data;

  cfg_page_sel #(.PB(PB), .AW(AW), .PAGE_WORDS(PAGE_WORDS)) page_i (
    .clk(clk), .rst(rst), .capture(capture), .remote_en(remote_en),
    .sel_local(sel_local), .sel_remote(sel_remote), .base_addr(base_addr));

  cfg_flash_rd #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT), .PAGE_WORDS(PAGE_WORDS)) rd_i (
    .clk(clk), .rst(rst), .load_addr(load_addr), .base_addr(base_addr),
    .start(rd_start), .next(rd_next), .flash_dq(flash_dq),
    .flash_addr(flash_addr), .flash_oe_n(flash_oe_n), .data_valid(rd_valid),
    .data_q(rd_data), .last_word(last_word));

  cfg_out_shift #(.DW(DW)) shift_i (
    .clk(clk), .rst(rst), .load(sh_load), .step(sh_step), .wide16(wide16),
    .par_mode(par_mode), .word_in(rd_data), .cfg_d0(cfg_d0),
    .cfg_dpar(cfg_dpar), .last_unit(last_unit));

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    nconfig_d = nconfig_q;
    dclk_d    = dclk_q;
    err_d     = err_q;
    capture   = 1'b0;
    load_addr = 1'b0;
    rd_start  = 1'b0;
    rd_next   = 1'b0;
    sh_load   = 1'b0;
    sh_step   = 1'b0;
    case (state_q)
      S_IDLE: begin
        capture   = 1'b1;
        nconfig_d = 1'b0;
        cnt_d     = '0;
        state_d   = S_PULSE;
      end
      S_PULSE: begin
        load_addr = (cnt_q == '0);
        if (cnt_q == PCW'(NCFG_LOW - 1)) begin
          nconfig_d = 1'b1;
          state_d   = S_WAIT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_WAIT: begin
        if (cfg_nstatus) begin
          rd_start = 1'b1;
          state_d  = S_READ;
        end
      end
      S_READ: begin
        if (cfg_done) begin
          state_d = S_DONE;
        end else if (rd_valid) begin
          sh_load = 1'b1;
          state_d = S_SHIFT;
        end
      end
      S_SHIFT: begin
        if (cfg_done) begin
          dclk_d  = 1'b0;
          state_d = S_DONE;
        end else if (!dclk_q) begin
          dclk_d = 1'b1;
        end else begin
          dclk_d = 1'b0;
          if (!last_unit) begin
            sh_step = 1'b1;
          end else begin
            rd_next = 1'b1;
            if (last_word) begin
              err_d   = 1'b1;
              state_d = S_ERR;
            end else begin
              rd_start = 1'b1;
              state_d  = S_READ;
            end
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      nconfig_q <= 1'b1;
      dclk_q    <= 1'b0;
      err_q     <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      nconfig_q <= nconfig_d;
      dclk_q    <= dclk_d;
      err_q     <= err_d;
      busy_q    <= state_d inside {S_PULSE, S_WAIT, S_READ, S_SHIFT};
    end
  end

  assign cfg_nconfig = nconfig_q;
  assign cfg_dclk    = dclk_q;
  assign busy        = busy_q;
  assign err         = err_q;

  // R2: the request pulse only begins straight out of reset
  a_r2_pulse_once: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_nconfig) |-> $past(state_q) == S_IDLE);

  // R3: nothing moves toward the flash or FPGA while status is low
  a_r3_wait_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT && !cfg_nstatus) |=> (flash_oe_n && !cfg_dclk));

  // R9: completion stops the clock and drops busy
  a_r9_done_stops: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SHIFT && cfg_done) |=> (!cfg_dclk && !busy && !err));

  // R10: the error flag only rises while completion is absent
  a_r10_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (!$past(cfg_done) && !cfg_dclk && !busy));

  // R11: data is held steady during each clock high phase
  a_r11_data_hold: assert property (@(posedge clk) disable iff (rst)
    cfg_dclk |-> ($stable(cfg_d0) && $stable(cfg_dpar)));

  // R11: the clock high phase is one cycle long
  a_r11_dclk_width: assert property (@(posedge clk) disable iff (rst)
    cfg_dclk |=> !cfg_dclk);
endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
  localparam int CLK_P  = 10;
  localparam int AW     = 12;
  localparam int PB     = 2;
  localparam int DW     = 16;
  localparam int PW     = 8;
  localparam int RDL    = 3;
  localparam int NLOW   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          par_mode = 1'b0, wide16 = 1'b0, remote_en = 1'b0;
  logic [PB-1:0] sel_local = '0, sel_remote = '0;
  logic [DW-1:0] flash_dq;
  logic [AW-1:0] flash_addr;
  logic          flash_oe_n, cfg_nconfig, cfg_dclk, cfg_d0, busy, err;
  logic          cfg_nstatus = 1'b1, cfg_done = 1'b0;
  logic [7:0]    cfg_dpar;

  int tests = 0, fails = 0;
  int done_after = 0, status_dly = 2;
  bit hold_status = 1'b0;

  // monitor state (owned by the monitor process)
  int ndclk, nreads, nlow, stcnt, lowrun;
  bit bad_lat, bad_dclk, prev_dclk, prev_oe;
  logic        bits  [0:255];
  logic [7:0]  bytes [0:255];
  logic [AW-1:0] addrs [0:63];

  always #(CLK_P/2) clk = ~clk;

  cfg_loader #(.AW(AW), .PB(PB), .DW(DW), .PAGE_WORDS(PW), .RD_LAT(RDL),
               .NCFG_LOW(NLOW)) dut_i (
    .clk(clk), .rst(rst), .par_mode(par_mode), .wide16(wide16),
    .remote_en(remote_en), .sel_local(sel_local), .sel_remote(sel_remote),
    .flash_dq(flash_dq), .flash_addr(flash_addr), .flash_oe_n(flash_oe_n),
    .cfg_nconfig(cfg_nconfig), .cfg_nstatus(cfg_nstatus), .cfg_done(cfg_done),
    .cfg_dclk(cfg_dclk), .cfg_d0(cfg_d0), .cfg_dpar(cfg_dpar),
    .busy(busy), .err(err));

  function automatic logic [15:0] fword(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] * 8'd7 + 8'h13};
  endfunction

  // flash model: data valid while enabled
  assign flash_dq = flash_oe_n ? 16'h0000 : fword(flash_addr);

  // FPGA model and port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      ndclk = 0; nreads = 0; nlow = 0; stcnt = 0; lowrun = 0;
      bad_lat = 0; bad_dclk = 0; prev_dclk = 0; prev_oe = 1;
      cfg_done = 1'b0;
    end else begin
      if (!cfg_nconfig) begin
        cfg_nstatus = 1'b0; stcnt = 0; nlow++;
      end else if (!cfg_nstatus) begin
        if (stcnt >= status_dly && !hold_status) cfg_nstatus = 1'b1;
        else stcnt++;
      end
      if (!flash_oe_n) begin
        if (prev_oe) begin
          if (nreads < 64) addrs[nreads] = flash_addr;
          nreads++; lowrun = 1;
        end else lowrun++;
      end else if (!prev_oe && lowrun != RDL) bad_lat = 1;
      if (cfg_dclk) begin
        if (prev_dclk) bad_dclk = 1;
        else begin
          if (ndclk < 256) begin bits[ndclk] = cfg_d0; bytes[ndclk] = cfg_dpar; end
          ndclk++;
        end
      end
      if (done_after != 0 && ndclk >= done_after) cfg_done = 1'b1;
      prev_dclk = cfg_dclk;
      prev_oe   = flash_oe_n;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_run(input logic par, input logic wide, input logic rem,
                           input logic [PB-1:0] sl, input logic [PB-1:0] sr,
                           input int dafter, input int sdly, input bit hold);
    @(posedge clk); #1;
    rst = 1'b1;
    par_mode = par; wide16 = wide; remote_en = rem;
    sel_local = sl; sel_remote = sr;
    done_after = dafter; status_dly = sdly; hold_status = hold;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wait_end();
    bit seen_idle = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!busy) begin seen_idle = 1; break; end
    end
    check(seen_idle, "run end (busy never fell)", busy, 0);
  endtask

  // compare captured serial stream; upw bits per word
  task automatic check_bits(input string tag, input int base, input int upw);
    int bad = 0;
    for (int i = 0; i < ndclk && i < 256; i++) begin
      logic [15:0] w = fword(AW'(base + i / upw));
      if (bits[i] !== w[i % upw]) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  // compare captured byte stream; upw bytes per word
  task automatic check_bytes(input string tag, input int base, input int upw);
    int bad = 0;
    for (int i = 0; i < ndclk && i < 256; i++) begin
      logic [15:0] w = fword(AW'(base + i / upw));
      logic [7:0]  e = (i % upw == 1) ? w[15:8] : w[7:0];
      if (bytes[i] !== e) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic check_addrs(input string tag, input int base);
    int bad = 0;
    for (int k = 0; k < nreads && k < 64; k++)
      if (addrs[k] !== AW'(base + k)) bad++;
    check(bad == 0, tag, bad, 0);
    check(!bad_lat, {tag, " enable width RD_LAT"}, bad_lat, 0);
  endtask

  task automatic t_reset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    check(cfg_nconfig == 1'b1, "R1 nconfig in reset", cfg_nconfig, 1);
    check(cfg_dclk == 1'b0,    "R1 dclk in reset", cfg_dclk, 0);
    check(flash_oe_n == 1'b1,  "R1 oe_n in reset", flash_oe_n, 1);
    check(busy == 1'b0 && err == 1'b0, "R1 busy/err in reset", {busy, err}, 0);
    check(flash_addr == '0,    "R1 addr in reset", flash_addr, 0);
  endtask

  task automatic t_serial8_local();
    start_run(1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 24, 3, 1'b0);
    wait_end();
    check(nlow == NLOW, "R2 request pulse length", nlow, NLOW);
    check(nreads == 3, "R5 read count serial8", nreads, 3);
    check(addrs[0] == AW'(2 * PW), "R4 local page base", addrs[0], 2 * PW);
    check_addrs("R5 serial8 addresses", 2 * PW);
    check(ndclk == 24, "R6 pulse count serial8", ndclk, 24);
    check_bits("R6 serial8 lsb-first stream", 2 * PW, 8);
    check(!bad_dclk, "R11 single-cycle dclk high", bad_dclk, 0);
    check(err == 1'b0, "R9 no err on completion", err, 0);
  endtask

  task automatic t_serial16_remote();
    start_run(1'b0, 1'b1, 1'b1, 2'd0, 2'd3, 32, 2, 1'b0);
    wait_end();
    check(addrs[0] == AW'(3 * PW), "R4 remote page base", addrs[0], 3 * PW);
    check(nreads == 2, "R7 read count serial16", nreads, 2);
    check_addrs("R5 serial16 addresses", 3 * PW);
    check(ndclk == 32, "R7 pulse count serial16", ndclk, 32);
    check_bits("R7 serial16 low byte first", 3 * PW, 16);
  endtask

  task automatic t_par8();
    start_run(1'b1, 1'b0, 1'b0, 2'd1, 2'd2, 5, 2, 1'b0);
    wait_end();
    check(addrs[0] == AW'(PW), "R4 remote select ignored", addrs[0], PW);
    check(nreads == 5, "R8 read count par8", nreads, 5);
    check(ndclk == 5, "R8 pulse count par8", ndclk, 5);
    check_bytes("R8 par8 byte stream", PW, 1);
  endtask

  task automatic t_par16();
    start_run(1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 6, 2, 1'b0);
    wait_end();
    check(nreads == 3, "R8 read count par16", nreads, 3);
    check(ndclk == 6, "R8 pulse count par16", ndclk, 6);
    check_bytes("R8 par16 low then high byte", 0, 2);
  endtask

  task automatic t_status_hold();
    start_run(1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 8, 2, 1'b1);
    repeat (40) @(negedge clk);
    check(nreads == 0, "R3 no read while status low", nreads, 0);
    check(ndclk == 0, "R3 no dclk while status low", ndclk, 0);
    check(busy == 1'b1 && cfg_nconfig == 1'b1, "R3 waiting state", {busy, cfg_nconfig}, 3);
    @(posedge clk); #1 hold_status = 1'b0;
    wait_end();
    check(ndclk == 8 && nreads == 1, "R3 proceeds after status", ndclk, 8);
  endtask

  task automatic t_done_midword();
    start_run(1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 5, 2, 1'b0);
    wait_end();
    repeat (20) @(negedge clk);
    check(ndclk == 5, "R9 clock stops mid-word", ndclk, 5);
    check(nreads == 1, "R9 no further read", nreads, 1);
    check(err == 1'b0 && busy == 1'b0, "R9 err/busy after done", {err, busy}, 0);
  endtask

  task automatic t_page_end();
    start_run(1'b1, 1'b1, 1'b1, 2'd3, 2'd1, 0, 2, 1'b0);
    wait_end();
    check(err == 1'b1, "R10 err at page end", err, 1);
    check(nreads == PW, "R10 whole page read", nreads, PW);
    check_addrs("R10 page addresses", PW);
    check(ndclk == 2 * PW, "R10 pulses for page", ndclk, 2 * PW);
    repeat (20) @(negedge clk);
    check(ndclk == 2 * PW && cfg_dclk == 1'b0, "R10 clock stays stopped", ndclk, 2 * PW);
  endtask

  initial begin
    #(CLK_P * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_serial8_local();
    t_serial16_remote();
    t_par8();
    t_par16();
    t_status_hold();
    t_done_midword();
    t_page_end();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule